// File: doc/BRIEF.md
# Clock-Calendar Update Timing and Interrupt Unit

This block supplies the once-per-second timekeeping cadence of a clock-calendar. A single free-running divider counts a slow tick enable (nominally 32.768 kHz) through one second. That divider drives everything else: the binary seconds, minutes and hours counters, a status bit that warns software before each time update, and three event flags. One flag marks the end of an update. One flags a match against three alarm bytes. The third fires at a programmable periodic rate.

Each flag has its own enable bit. Any flag whose enable is set pulls an active-low interrupt line. Software reaches the time, alarm and control registers through a simple single-cycle register port. A read of the status register returns the flags and clears them.

The event timing is fixed relative to each update. The warning bit rises 8 ticks before the update. The end-of-update and alarm flags follow it by one tick. The periodic flag is phased so that each firing lands half a period plus 8 ticks before an update.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset all time, alarm and control registers read 0x00, every flag is clear, the divider is at 0 and `irqN` is high.
- R2: Control register A (address 6) bit 7 reads 1 while the divider sits in its last 8 counts before wrapping. It reads 0 at all other times, so it is high for exactly the 8 ticks that precede each update.
- R3: On the tick that wraps the divider, seconds advance by one. A counter holding its last value (59, 59, 23) or any larger value returns to 0 and carries into the next unit. A register write in the same cycle takes priority over the increment. Seconds, minutes and hours sit at addresses 0, 2 and 4.
- R4: On the tick after each update, the update-ended flag (status register C, address 8, bit 4) is set.
- R5: On that same tick, the alarm flag (C bit 5) is set when each alarm byte (addresses 1, 3 and 5, for seconds, minutes and hours) either equals its time counter or has bits 7 and 6 both set.
- R6: Register A bits 3:0 hold the rate code RS. Code 0 disables the periodic flag. Any other code gives a period P = 2^(RS-1) ticks. The periodic flag (C bit 6) is set on each tick whose resulting divider value n satisfies (n + 8) mod P = P/2. P must not exceed one second.
- R7: Register B (address 7) holds the enables: bit 6 for periodic, bit 5 for alarm and bit 4 for update-ended. `irqN` is low, and C bit 7 is 1, exactly when some flag is set together with its enable.
- R8: A read strobe at address 8 clears all flags on that clock edge. A flag that is set on the same edge survives the clear.
- R9: Writes to address 8, to bits 7:4 of register A, and to bits 7 and 3:0 of register B have no effect. Those bits read 0, and so do addresses 9 to 15.
- R10: The divider, time counters and flags change only on cycles where `tickEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable per slow tick |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears flags at address 8) |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions rely on three properties of the configuration and the inputs. The ticks per second must be a power of two. Any rate code in use must give a period no longer than one second. Read and write strobes must be single-cycle pulses at a stable address. The stimulus uses only rate codes 1, 3 and 0, configures registers mostly while ticks are held off, and spaces ticks both on every clock and on every third clock. It also includes a read that coincides with a periodic set, and a time value written above its wrap limit.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  // strobes issued by the control path, one clock wide
  typedef struct packed {
    logic update;    // divider wrapped: advance time
    logic ended;     // update complete: raise ended flag, compare alarm
    logic periodic;  // periodic rate point reached
  } rtcStrobe_t;

  localparam logic [ADDR_W-1:0] ADDR_CTRL_A = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_B = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_STAT_C = 4'd8;

  localparam int BIT_IRQ = 7;
  localparam int BIT_PF  = 6;
  localparam int BIT_AF  = 5;
  localparam int BIT_UF  = 4;
  localparam int BIT_UIP = 7;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  parameter int END_DELAY     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [3:0] rateSel,
  output rtcStrobe_t strobes,
  output logic       uip
);
  localparam int DIV_W = $clog2(TICKS_PER_SEC);
  localparam int PH_W  = (DIV_W > 15) ? DIV_W + 1 : 16;
  localparam logic [DIV_W-1:0] END_POINT = DIV_W'(END_DELAY);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] nextCnt;
  logic [3:0]       rateShift;
  logic [PH_W-1:0]  periodLen;
  logic [PH_W-1:0]  periodMask;
  logic [PH_W-1:0]  phase;
  logic             rateHit;

  assign nextCnt = divCnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tickEn) divCnt <= nextCnt;
  end

  // periodic point: (next count + warning window) mod period == half period
  always_comb begin
    rateShift  = rateSel - 4'd1;
    periodLen  = PH_W'(1) << rateShift;
    periodMask = periodLen - PH_W'(1);
    phase      = PH_W'(nextCnt) + PH_W'(UIP_TICKS);
    rateHit    = (rateSel != 4'd0) && ((phase & periodMask) == (periodLen >> 1));
  end

  always_comb begin
    strobes.update   = tickEn && (nextCnt == '0);
    strobes.ended    = tickEn && (nextCnt == END_POINT);
    strobes.periodic = tickEn && rateHit;
  end

  generate
    if (UIP_TICKS > 0) begin : gUip
      localparam logic [DIV_W-1:0] UIP_START = DIV_W'(TICKS_PER_SEC - UIP_TICKS);
      assign uip = (divCnt >= UIP_START);

      AST_UIP_AT_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
        strobes.update |-> uip); // R2
      AST_UIP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        strobes.update |=> !uip); // R2
    end else begin : gNoUip
      assign uip = 1'b0;
    end
  endgenerate

  AST_PF_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 4'd0) |-> !strobes.periodic); // R6
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> (strobes == '0)); // R10
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(divCnt)); // R10
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobes,
  input  logic              uip,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqN,
  output logic [3:0]        rateSel
);
  localparam int UNITS = 3;

  function automatic int unitLimit(input int idx);
    case (idx)
      0:       return SEC_LIMIT;
      1:       return MIN_LIMIT;
      default: return HOUR_LIMIT;
    endcase
  endfunction

  logic [UNITS-1:0]             carry;
  logic [UNITS-1:0]             unitMatch;
  logic [UNITS-1:0][DATA_W-1:0] timeBus;
  logic [UNITS-1:0][DATA_W-1:0] alarmBus;

  assign carry[0] = strobes.update;

  generate
    for (genvar u = 0; u < UNITS; u++) begin : gUnit
      localparam logic [ADDR_W-1:0] TIME_ADDR  = ADDR_W'(2 * u);
      localparam logic [ADDR_W-1:0] ALARM_ADDR = ADDR_W'(2 * u + 1);
      localparam logic [DATA_W-1:0] LAST       = DATA_W'(unitLimit(u) - 1);

      logic [DATA_W-1:0] timeReg;
      logic [DATA_W-1:0] alarmReg;
      logic              atLast;
      logic              timeWe;
      logic              alarmWe;

      assign atLast  = (timeReg >= LAST);
      assign timeWe  = regWe && (regAddr == TIME_ADDR);
      assign alarmWe = regWe && (regAddr == ALARM_ADDR);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          timeReg <= '0;
        else if (timeWe)    timeReg <= regWdata;
        else if (carry[u])  timeReg <= atLast ? '0 : timeReg + DATA_W'(1);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        alarmReg <= '0;
        else if (alarmWe) alarmReg <= regWdata;
      end

      if (u < UNITS - 1) begin : gCarry
        assign carry[u+1] = carry[u] && atLast;
      end

      // top two bits set: this byte matches any value
      assign unitMatch[u] = (alarmReg[7:6] == 2'b11) || (alarmReg == timeReg);
      assign timeBus[u]   = timeReg;
      assign alarmBus[u]  = alarmReg;

      AST_UNIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
        (carry[u] && !timeWe && atLast) |=> (timeReg == '0)); // R3
    end
  endgenerate

  logic rateWe, enWe, statRead;
  logic pieReg, aieReg, uieReg;
  logic pfReg, afReg, ufReg;
  logic setAlarm, irqAny;

  assign rateWe   = regWe && (regAddr == ADDR_CTRL_A);
  assign enWe     = regWe && (regAddr == ADDR_CTRL_B);
  assign statRead = regRe && (regAddr == ADDR_STAT_C);
  assign setAlarm = strobes.ended && (&unitMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel <= '0;
      pieReg  <= 1'b0;
      aieReg  <= 1'b0;
      uieReg  <= 1'b0;
    end else begin
      if (rateWe) rateSel <= regWdata[3:0];
      if (enWe) begin
        pieReg <= regWdata[BIT_PF];
        aieReg <= regWdata[BIT_AF];
        uieReg <= regWdata[BIT_UF];
      end
    end
  end

  // a set on the clearing edge wins so no event is lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfReg <= 1'b0;
      afReg <= 1'b0;
      ufReg <= 1'b0;
    end else begin
      pfReg <= (pfReg && !statRead) || strobes.periodic;
      afReg <= (afReg && !statRead) || setAlarm;
      ufReg <= (ufReg && !statRead) || strobes.ended;
    end
  end

  assign irqAny = (pfReg && pieReg) || (afReg && aieReg) || (ufReg && uieReg);
  assign irqN   = !irqAny;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL_A: begin
        regRdata[BIT_UIP] = uip;
        regRdata[3:0]     = rateSel;
      end
      ADDR_CTRL_B: begin
        regRdata[BIT_PF] = pieReg;
        regRdata[BIT_AF] = aieReg;
        regRdata[BIT_UF] = uieReg;
      end
      ADDR_STAT_C: begin
        regRdata[BIT_IRQ] = irqAny;
        regRdata[BIT_PF]  = pfReg;
        regRdata[BIT_AF]  = afReg;
        regRdata[BIT_UF]  = ufReg;
      end
      default: begin
        for (int u = 0; u < UNITS; u++) begin
          if (regAddr == ADDR_W'(2 * u))     regRdata = timeBus[u];
          if (regAddr == ADDR_W'(2 * u + 1)) regRdata = alarmBus[u];
        end
      end
    endcase
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !strobes.ended && !strobes.periodic) |=> !(pfReg || afReg || ufReg)); // R8
  AST_AF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(afReg) |-> $past(strobes.ended)); // R5
  AST_UF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ufReg) |-> $past(strobes.ended)); // R4
  AST_PF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfReg) |-> $past(strobes.periodic)); // R6
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  parameter int END_DELAY     = 1,
  parameter int SEC_LIMIT     = 60,
  parameter int MIN_LIMIT     = 60,
  parameter int HOUR_LIMIT    = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irqN
);
  rtcStrobe_t strobes;
  logic       uip;
  logic [3:0] rateSel;

  rtc_alarm_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS),
    .END_DELAY    (END_DELAY)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .rateSel(rateSel),
    .strobes(strobes),
    .uip    (uip)
  );

  rtc_alarm_dp #(
    .SEC_LIMIT (SEC_LIMIT),
    .MIN_LIMIT (MIN_LIMIT),
    .HOUR_LIMIT(HOUR_LIMIT)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .uip     (uip),
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqN    (irqN),
    .rateSel (rateSel)
  );
endmodule

// File: tb/rtc_alarm_irq_test.sv
`timescale 1ns/100ps
module rtc_alarm_irq_test;
  localparam int T = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWe = 1'b0;
  logic       regRe = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       irqN;

  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  // behavioural reference state
  int mCnt = 0;
  int mTime[3] = '{0, 0, 0};
  int mAlm[3] = '{0, 0, 0};
  int mRs = 0, mPie = 0, mAie = 0, mUie = 0;
  int mPf = 0, mAf = 0, mUf = 0;

  rtc_alarm_irq #(.TICKS_PER_SEC(T)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqN(irqN)
  );

  always #2.5 clk = ~clk;

  function automatic bit almOk(input int i);
    return ((mAlm[i] & 8'hC0) == 8'hC0) || (mAlm[i] == mTime[i]);
  endfunction

  function automatic bit modelIrq();
    return (mPf != 0 && mPie != 0) || (mAf != 0 && mAie != 0) || (mUf != 0 && mUie != 0);
  endfunction

  function automatic int modelRead(input int a);
    case (a)
      0: return mTime[0];
      1: return mAlm[0];
      2: return mTime[1];
      3: return mAlm[1];
      4: return mTime[2];
      5: return mAlm[2];
      6: return ((mCnt >= T - 8) ? 128 : 0) + mRs;
      7: return mPie * 64 + mAie * 32 + mUie * 16;
      8: return (modelIrq() ? 128 : 0) + mPf * 64 + mAf * 32 + mUf * 16;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : refModel
    int n, p, lim;
    bit sU, sA, sP, carry, clr;
    if (!rstN) begin
      mCnt = 0; mRs = 0; mPie = 0; mAie = 0; mUie = 0; mPf = 0; mAf = 0; mUf = 0;
      for (int i = 0; i < 3; i++) begin mTime[i] = 0; mAlm[i] = 0; end
    end else begin
      clr = regRe && (regAddr == 4'd8);
      sU = 0; sA = 0; sP = 0; carry = 0;
      if (tickEn) begin
        n = (mCnt + 1) % T;
        carry = (n == 0);
        if (n == 1) begin
          sU = 1;
          sA = almOk(0) && almOk(1) && almOk(2);
        end
        if (mRs != 0) begin
          p = 1 << (mRs - 1);
          if (((n + 8) % p) == p / 2) sP = 1;
        end
        mCnt = n;
      end
      for (int i = 0; i < 3; i++) begin
        lim = (i == 2) ? 24 : 60;
        if (carry) begin
          if (mTime[i] >= lim - 1) mTime[i] = 0;
          else begin mTime[i] = mTime[i] + 1; carry = 0; end
        end
      end
      if (regWe) begin
        if (regAddr < 4'd6) begin
          if (regAddr[0]) mAlm[regAddr >> 1] = regWdata;
          else mTime[regAddr >> 1] = regWdata;
        end else if (regAddr == 4'd6) mRs = regWdata & 15;
        else if (regAddr == 4'd7) begin
          mPie = regWdata[6]; mAie = regWdata[5]; mUie = regWdata[4];
        end
      end
      mPf = ((mPf != 0) && !clr) || sP;
      mAf = ((mAf != 0) && !clr) || sA;
      mUf = ((mUf != 0) && !clr) || sU;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (irqN !== !modelIrq()) begin
        nFails++;
        $display("FAIL R7: irqN got %0b expected %0b at %0t", irqN, !modelIrq(), $time);
      end
      nChecks++;
      if (regRdata !== 8'(modelRead(int'(regAddr)))) begin
        nFails++;
        $display("FAIL %s: addr %0d read 0x%0h expected 0x%0h at %0t", curTag,
                 regAddr, regRdata, modelRead(int'(regAddr)), $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(input int a, output int v);
    regAddr = 4'(a);
    #0.2;
    v = int'(regRdata);
  endtask

  task automatic wr(input int a, input int d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 8'(d);
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic rdClr();
    regRe = 1'b1; regAddr = 4'd8;
    tick(1);
    regRe = 1'b0;
  endtask

  task automatic runThirds(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = (i % 3 == 0);
      tick(1);
    end
    tickEn = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin : watchdog
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin : stim
    int v;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1: reset state
    curTag = "R1";
    for (int a = 0; a < 9; a++) begin
      peek(a, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irqN idle", int'(irqN), 1);

    // configure 23:59:58, alarm at hh=0 mm=0 with seconds don't-care
    curTag = "R3";
    wr(4, 23); wr(2, 59); wr(0, 58);
    wr(1, 8'hC0); wr(3, 0); wr(5, 0);
    wr(7, 8'h30);

    tickEn = 1'b1;
    tick(1010);
    peek(6, v); chk("R2 warning low early", v, 8'h00);
    tick(10);
    peek(6, v); chk("R2 warning high before update", v, 8'h80);
    tick(5);
    curTag = "R4";
    peek(8, v); chk("R4 ended flag with irq summary", v, 8'h90);
    chk("R7 irq low on enabled ended flag", int'(irqN), 0);
    peek(0, v); chk("R3 seconds advanced", v, 59);
    peek(4, v); chk("R3 hours held", v, 23);
    rdClr();
    curTag = "R8";
    peek(8, v); chk("R8 flags cleared by read", v, 0);
    chk("R8 irq released", int'(irqN), 1);

    curTag = "R5";
    tick(1023);
    peek(8, v); chk("R5 alarm with don't-care seconds", v, 8'hB0);
    peek(0, v); chk("R3 seconds wrap", v, 0);
    peek(2, v); chk("R3 minutes wrap", v, 0);
    peek(4, v); chk("R3 hours wrap", v, 0);
    rdClr();
    tickEn = 1'b0;

    // exact seconds alarm that does not match
    wr(1, 5);
    tickEn = 1'b1;
    tick(1023);
    peek(8, v); chk("R5 no alarm on mismatch", v, 8'h90);
    rdClr();
    tickEn = 1'b0;

    // periodic rate 4 ticks
    curTag = "R6";
    wr(7, 8'h40); wr(6, 3); rdClr();
    tickEn = 1'b1;
    tick(8);
    peek(8, v); chk("R6 periodic flag rate code 3", v, 8'hC0);
    chk("R6 periodic irq", int'(irqN), 0);
    wr(6, 1);
    rdClr();
    curTag = "R8";
    peek(8, v); chk("R8 set wins over clear", v, 8'hC0);
    tickEn = 1'b0;
    curTag = "R6";
    wr(6, 0); rdClr();
    tickEn = 1'b1;
    tick(100);
    peek(8, v); chk("R6 code 0 disables periodic", v, 8'h00);
    chk("R6 irq idle when disabled", int'(irqN), 1);
    tickEn = 1'b0;

    // R9: ignored writes and reserved bits
    curTag = "R9";
    wr(6, 8'hF5);
    peek(6, v); chk("R9 reserved bits of A", v, 8'h05);
    wr(8, 8'hFF);
    peek(8, v); chk("R9 status not writable", v, 8'h00);
    wr(7, 8'hFF);
    peek(7, v); chk("R9 reserved bits of B", v, 8'h70);
    peek(12, v); chk("R9 unused address", v, 0);
    wr(7, 0); wr(6, 0);

    // R10: no tick, no change
    curTag = "R10";
    tick(3000);
    peek(0, v); chk("R10 seconds frozen", v, 1);
    peek(8, v); chk("R10 flags frozen", v, 0);

    // over-range seconds under sparse ticks
    curTag = "R3";
    wr(0, 70); wr(2, 5);
    runThirds(3000);
    peek(0, v); chk("R3 over-range seconds wrap", v, 0);
    peek(2, v); chk("R3 carry from over-range", v, 6);
    peek(8, v); chk("R7 flag without enable", v, 8'h10);
    chk("R7 irq stays high without enable", int'(irqN), 1);

    tick(2);
    summary();
  end
endmodule